// File: doc/BRIEF.md
# Sixteen-bit timer with capture and reload register

This block is a 16-bit timer/counter with a companion 16-bit capture/reload register. Software reaches both through a byte-wide register port, along with a control byte and a mode byte. The control byte starts and stops the timer, picks the counting source and holds the two event flags. The mode byte picks the up/down behaviour, turns on the clock output and selects the time base.

The block has three uses. In capture mode, a falling edge on the external event input copies the running count into the capture register. In reload mode, the timer counts up and restarts from the reload value when it rolls over. With up/down enabled it can instead count down, steered by a direction pin. In generator mode, used for a baud-rate tick or a square-wave clock, the time base is forced to divide-by-2. The baud tick pulse and the clock output are both driven by the timer's overflow.

Top module: `tcr_timer16`

## Requirements
- R1: After reset, the count, the capture/reload register, the control byte and the mode byte read 0, the time base is divide-by-12, and `baud_tick_o` and `clk_o` are low.
- R2: While the run bit (control bit 0) is set and the timer uses its internal time base, the count advances once every DIV_SLOW (12) cycles. It advances once every DIV_FAST (4) cycles when mode bit 2 is set. While the run bit is clear, the count holds.
- R3: In reload mode (control bit 1 clear) counting up, a tick at 0xFFFF loads the capture/reload value.
- R4: With up/down enabled (mode bit 0) and `dir_i` low, the count decrements. A tick while the count equals the reload value loads 0xFFFF. When `dir_i` is high, the timer counts up.
- R5: In capture mode (control bit 1 set), a falling edge on `ext_i` copies the count into the capture register and sets the capture flag (control bit 5). In this mode the count wraps from 0xFFFF to 0x0000 with no reload.
- R6: When a capture and a software write to the capture register fall in the same cycle, the captured count is kept.
- R7: In baud mode (control bit 3), the time base is divide-by-2 whatever mode bit 2 holds. `baud_tick_o` pulses for one cycle on each overflow.
- R8: When clock output is enabled (mode bit 1), the time base is divide-by-2 and `clk_o` toggles on every overflow.
- R9: With the external source selected (control bit 2) and not in generator mode, the count advances once per falling edge of `ext_i` while running.
- R10: The register map is: 0 count low, 1 count high, 2 capture low, 3 capture high, 4 control, 5 mode. Other addresses read 0. Reserved bits (control 7:6, mode 7:3) read 0.
- R11: Every overflow or down-reload event sets the overflow flag (control bit 4). The flags stay set until software writes them clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| ext_i | input | 1 | External count/capture input, falling-edge active |
| dir_i | input | 1 | Count direction when up/down is enabled (1 = up) |
| baud_tick_o | output | 1 | One-cycle pulse per overflow in baud mode |
| clk_o | output | 1 | Square-wave clock output |

## Verification
On every cycle, the assertions check several properties. Both kinds of reload must land on the correct value. A capture must copy the count of the cycle before it and raise its flag. The count must hold while the timer is stopped. The baud pulse must last a single cycle. `clk_o` may move only after an overflow, and the generator time base may never tick on two cycles in a row. Some behaviour only the bench scenarios can show: the exact divide ratios, the ordering of a capture against a colliding register write, the edge counting of the external source, and the number of baud pulses and clock toggles in a fixed window.

// File: rtl/tcr_pkg.sv
package tcr_pkg;
    localparam int CNT_W = 16;
    localparam logic [CNT_W-1:0] CNT_MAX = 16'hFFFF;

    localparam logic [2:0] ADR_CNT_L = 3'd0;
    localparam logic [2:0] ADR_CNT_H = 3'd1;
    localparam logic [2:0] ADR_CAP_L = 3'd2;
    localparam logic [2:0] ADR_CAP_H = 3'd3;
    localparam logic [2:0] ADR_CTRL  = 3'd4;
    localparam logic [2:0] ADR_MODE  = 3'd5;

    typedef struct packed {
        logic [1:0] rsvd;
        logic       cap_f;
        logic       ovf_f;
        logic       baud;
        logic       ext_src;
        logic       cap_mode;
        logic       run;
    } ctrl_t;

    typedef struct packed {
        logic [4:0] rsvd;
        logic       tb_fast;
        logic       clk_out;
        logic       updown;
    } mode_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap;
        ctrl_t            ctrl;
        mode_t            mode;
        logic             baud_tick;
        logic             clk_out;
    } tmr_state_t;
endpackage

// File: rtl/tcr_prescale.sv
module tcr_prescale #(
    parameter int PRE_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic [PRE_W-1:0] limit_i,
    output logic             tick_o
);
    logic [PRE_W-1:0] pre_d, pre_q;
    logic             at_end;

    always_comb begin
        at_end = (pre_q >= (limit_i - PRE_W'(1)));
        tick_o = run_i && at_end;
        if (!run_i || at_end) pre_d = '0;
        else                  pre_d = pre_q + PRE_W'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pre_q <= '0;
        else         pre_q <= pre_d;
    end
endmodule

// File: rtl/tcr_fall_det.sv
module tcr_fall_det #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sig_i,
    output logic fall_o
);
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d   = {sh_q[STAGES-1:0], sig_i};
        fall_o = sh_q[STAGES] && !sh_q[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '1;
        else         sh_q <= sh_d;
    end
endmodule

// File: rtl/tcr_timer16.sv
module tcr_timer16
    import tcr_pkg::*;
#(
    parameter int DIV_SLOW    = 12,
    parameter int DIV_FAST    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wr_en_i,
    input  logic [2:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    input  logic       ext_i,
    input  logic       dir_i,
    output logic       baud_tick_o,
    output logic       clk_o
);
    localparam int MAX_DIV = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int PRE_W   = $clog2(MAX_DIV + 1);

    tmr_state_t st_d, st_q;

    logic             fast;
    logic [PRE_W-1:0] pre_limit;
    logic             pre_tick;
    logic             ext_fall;
    logic             cnt_tick;
    logic             up;
    logic             ovf_evt;
    logic             cap_evt;
    logic             wr_cnt;
    logic             wr_cap;
    logic             run;
    logic             cap_mode;
    logic             cap_flag;

    assign run      = st_q.ctrl.run;
    assign cap_mode = st_q.ctrl.cap_mode;
    assign cap_flag = st_q.ctrl.cap_f;
    assign fast     = st_q.ctrl.baud || st_q.mode.clk_out;

    always_comb begin
        if (fast)                 pre_limit = PRE_W'(2);
        else if (st_q.mode.tb_fast) pre_limit = PRE_W'(DIV_FAST);
        else                      pre_limit = PRE_W'(DIV_SLOW);
    end

    tcr_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .run_i   (run),
        .limit_i (pre_limit),
        .tick_o  (pre_tick)
    );

    tcr_fall_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sig_i  (ext_i),
        .fall_o (ext_fall)
    );

    always_comb begin
        st_d = st_q;
        st_d.baud_tick = 1'b0;

        wr_cnt = wr_en_i && (addr_i == ADR_CNT_L || addr_i == ADR_CNT_H);
        wr_cap = wr_en_i && (addr_i == ADR_CAP_L || addr_i == ADR_CAP_H);

        if (st_q.ctrl.ext_src && !fast) cnt_tick = run && ext_fall;
        else                            cnt_tick = pre_tick;

        up      = cap_mode || fast || !st_q.mode.updown || dir_i;
        ovf_evt = cnt_tick && (up ? (st_q.cnt == CNT_MAX) : (st_q.cnt == st_q.cap));
        cap_evt = cap_mode && !fast && ext_fall;

        // counting
        if (cnt_tick) begin
            if (ovf_evt) begin
                if (cap_mode && !fast) st_d.cnt = '0;
                else if (up)           st_d.cnt = st_q.cap;
                else                   st_d.cnt = CNT_MAX;
            end else if (up) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end

        // software writes; count writes win over counting
        if (wr_en_i) begin
            case (addr_i)
                ADR_CNT_L: st_d.cnt[7:0]  = wdata_i;
                ADR_CNT_H: st_d.cnt[15:8] = wdata_i;
                ADR_CAP_L: st_d.cap[7:0]  = wdata_i;
                ADR_CAP_H: st_d.cap[15:8] = wdata_i;
                ADR_CTRL: begin
                    st_d.ctrl      = ctrl_t'(wdata_i);
                    st_d.ctrl.rsvd = '0;
                end
                ADR_MODE: begin
                    st_d.mode      = mode_t'(wdata_i);
                    st_d.mode.rsvd = '0;
                end
                default: ;
            endcase
        end

        // hardware events win over software writes
        if (cap_evt) begin
            st_d.cap        = st_q.cnt;
            st_d.ctrl.cap_f = 1'b1;
        end
        if (ovf_evt) begin
            st_d.ctrl.ovf_f = 1'b1;
            st_d.baud_tick  = st_q.ctrl.baud;
            if (st_q.mode.clk_out) st_d.clk_out = !st_q.clk_out;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        case (addr_i)
            ADR_CNT_L: rdata_o = st_q.cnt[7:0];
            ADR_CNT_H: rdata_o = st_q.cnt[15:8];
            ADR_CAP_L: rdata_o = st_q.cap[7:0];
            ADR_CAP_H: rdata_o = st_q.cap[15:8];
            ADR_CTRL:  rdata_o = st_q.ctrl;
            ADR_MODE:  rdata_o = st_q.mode;
            default:   rdata_o = 8'h00;
        endcase
    end

    assign baud_tick_o = st_q.baud_tick;
    assign clk_o       = st_q.clk_out;
endmodule

// File: rtl/tcr_timer16_chk.sv
module tcr_timer16_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic [15:0] cnt,
    input logic [15:0] cap,
    input logic        cnt_tick,
    input logic        cap_evt,
    input logic        ovf_evt,
    input logic        wr_cnt,
    input logic        cap_mode,
    input logic        up,
    input logic        run,
    input logic        fast,
    input logic        cap_flag,
    input logic        baud_tick_o,
    input logic        clk_o
);
    AST_UP_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_evt && !cap_mode && up && !wr_cnt) |=> (cnt == $past(cap))); // R3

    AST_DOWN_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ovf_evt && !up && !wr_cnt) |=> (cnt == 16'hFFFF)); // R4

    AST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_evt |=> (cap == $past(cnt)) && cap_flag); // R5

    AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run && !wr_cnt) |=> (cnt == $past(cnt))); // R2

    AST_BAUD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        baud_tick_o |=> !baud_tick_o); // R7

    AST_CLK_ON_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clk_o != $past(clk_o)) |-> $past(ovf_evt)); // R8

    AST_FAST_DIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fast && cnt_tick) |=> !cnt_tick); // R7
endmodule

bind tcr_timer16 tcr_timer16_chk chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cnt         (st_q.cnt),
    .cap         (st_q.cap),
    .cnt_tick    (cnt_tick),
    .cap_evt     (cap_evt),
    .ovf_evt     (ovf_evt),
    .wr_cnt      (wr_cnt),
    .cap_mode    (cap_mode),
    .up          (up),
    .run         (run),
    .fast        (fast),
    .cap_flag    (cap_flag),
    .baud_tick_o (baud_tick_o),
    .clk_o       (clk_o)
);

// File: tb/tcr_timer16_tb_top.sv
`timescale 1ns/1ps
module tcr_timer16_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       ext = 1'b1;
    logic       dir = 1'b1;
    logic       baud_tick;
    logic       clk_out;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    tcr_timer16 dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .ext_i(ext), .dir_i(dir),
        .baud_tick_o(baud_tick), .clk_o(clk_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // called at a negedge; write lands on the next posedge
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr16(input logic [2:0] a, input logic [15:0] d);
        wr(a, d[7:0]);
        wr(a + 3'd1, d[15:8]);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a; #0.2; d = rdata;
    endtask

    task automatic rd16(input logic [2:0] a, output logic [15:0] d);
        logic [7:0] lo, hi;
        rd(a, lo); rd(a + 3'd1, hi);
        d = {hi, lo};
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_ext();
        ext = 1'b0; wait_n(4);
        ext = 1'b1; wait_n(4);
    endtask

    task automatic t_reset();
        logic [15:0] v; logic [7:0] b;
        rd16(3'd0, v); check("R1 count", v, 0);
        rd16(3'd2, v); check("R1 capture", v, 0);
        rd(3'd4, b);   check("R1 control", b, 0);
        rd(3'd5, b);   check("R1 mode", b, 0);
        check("R1 outputs", {baud_tick, clk_out}, 0);
    endtask

    task automatic t_rate();
        logic [15:0] v; logic [7:0] b;
        wr(3'd4, 8'h01);
        wait_n(66);
        rd16(3'd0, v); check("R2 divide-by-12", v, 5);
        wr(3'd4, 8'h00);
        wait_n(30);
        rd16(3'd0, v); check("R2 hold when stopped", v, 5);
        wr(3'd5, 8'hFF);
        rd(3'd5, b); check("R10 mode reserved bits", b, 8'h07);
        wr(3'd5, 8'h04);
        wr16(3'd0, 16'h0000);
        wr(3'd4, 8'h01);
        wait_n(18);
        rd16(3'd0, v); check("R2 divide-by-4", v, 4);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_up_reload();
        logic [15:0] v; logic [7:0] b;
        wr16(3'd2, 16'hFF00);
        wr16(3'd0, 16'hFFFE);
        wr(3'd4, 8'h01);
        wait_n(6);
        rd16(3'd0, v); check("R3 reaches FFFF", v, 16'hFFFF);
        rd(3'd4, b);   check("R11 no flag before overflow", b[4], 0);
        wait_n(4);
        rd16(3'd0, v); check("R3 reload value", v, 16'hFF00);
        rd(3'd4, b);   check("R11 overflow flag", b[4], 1);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_down_reload();
        logic [15:0] v; logic [7:0] b;
        wr(3'd5, 8'h05);
        dir = 1'b0;
        wr16(3'd2, 16'h0010);
        wr16(3'd0, 16'h0012);
        wr(3'd4, 8'h01);
        wait_n(10);
        rd16(3'd0, v); check("R4 counts down to reload value", v, 16'h0010);
        rd(3'd4, b);   check("R4 no flag yet", b[4], 0);
        wait_n(4);
        rd16(3'd0, v); check("R4 loads FFFF", v, 16'hFFFF);
        rd(3'd4, b);   check("R11 flag on down reload", b[4], 1);
        wr(3'd4, 8'h00);
        dir = 1'b1;
        wr16(3'd0, 16'h0020);
        wr(3'd4, 8'h01);
        wait_n(6);
        rd16(3'd0, v); check("R4 dir high counts up", v, 16'h0021);
        wr(3'd4, 8'h00);
        wr(3'd5, 8'h00);
    endtask

    task automatic t_capture();
        logic [15:0] v; logic [7:0] b;
        wr(3'd4, 8'h02);
        wr16(3'd0, 16'h1234);
        pulse_ext();
        rd16(3'd2, v); check("R5 captured count", v, 16'h1234);
        rd(3'd4, b);   check("R5 capture flag", b[5], 1);
        wr(3'd4, 8'h02);
        rd(3'd4, b);   check("R11 flag cleared by write", b[5], 0);
    endtask

    task automatic t_cap_priority();
        logic [15:0] v;
        wr16(3'd0, 16'h5678);
        ext = 1'b0;
        wait_n(2);
        wr(3'd2, 8'hAA);
        wait_n(3);
        ext = 1'b1; wait_n(4);
        rd16(3'd2, v); check("R6 capture wins over write", v, 16'h5678);
    endtask

    task automatic t_cap_wrap();
        logic [15:0] v; logic [7:0] b;
        wr(3'd5, 8'h04);
        wr16(3'd0, 16'hFFFF);
        wr(3'd4, 8'h03);
        wait_n(6);
        rd16(3'd0, v); check("R5 wraps to zero", v, 16'h0000);
        rd(3'd4, b);   check("R11 flag in capture mode", b[4], 1);
        wr(3'd4, 8'h00);
        wr(3'd5, 8'h00);
    endtask

    task automatic t_ext_count();
        logic [15:0] v;
        wr16(3'd0, 16'h0000);
        wr(3'd4, 8'h05);
        pulse_ext(); pulse_ext(); pulse_ext();
        rd16(3'd0, v); check("R9 counts falling edges", v, 3);
        wr(3'd4, 8'h00);
    endtask

    task automatic t_gen(input logic [7:0] ctrl_v, input logic [7:0] mode_v,
                         input int exp_ticks, input int exp_tog, input string tag);
        int ticks = 0, togs = 0;
        logic last;
        wr(3'd5, mode_v);
        wr16(3'd2, 16'hFFFE);
        wr16(3'd0, 16'hFFFE);
        last = clk_out;
        wr(3'd4, ctrl_v);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (baud_tick) ticks++;
            if (clk_out != last) togs++;
            last = clk_out;
        end
        check({tag, " baud pulses"}, ticks, exp_ticks);
        check({tag, " clock toggles"}, togs, exp_tog);
        wr(3'd4, 8'h00);
        wr(3'd5, 8'h00);
    endtask

    task automatic t_map();
        logic [7:0] b;
        wr(3'd4, 8'hC0);
        rd(3'd4, b); check("R10 control reserved bits", b, 0);
        rd(3'd6, b); check("R10 unmapped address", b, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        t_reset();
        t_rate();
        t_up_reload();
        t_down_reload();
        t_capture();
        t_cap_priority();
        t_cap_wrap();
        t_ext_count();
        t_gen(8'h09, 8'h00, 10, 0, "R7");
        t_gen(8'h01, 8'h02, 0, 10, "R8");
        t_map();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule